// File: doc/BRIEF.md
# Slave Port Round-Robin Arbiter

This block decides which of several masters owns a single slave port. Masters raise a request and, while they own the port, pulse a per-master transfer-end strobe at the last cycle of each beat. The arbiter hands the port out in rotating order. It registers a one-hot grant, a connected flag and the binary index of the owner. Address decoding, the data path and the bus protocol sit elsewhere. Only ownership and the latency it costs are modelled here.

When nobody is asking for the port, a two-bit policy input chooses what the port does. It can drop every master. It can stay parked on whichever master used it last. It can return to a configured home master. A master that already holds a parked grant when it raises its request sees the grant in that same cycle. Any other master gets its grant one cycle after it asks. An optional slot counter limits how long one master can keep a burst going while others wait.

Top module: `slave_port_arbiter`

## Requirements
- R1: With the rotation pointer at its reset value of 0, masters that request in the same cycle are served lowest index first.
- R2: After a master is granted, the rotation pointer moves to the next index, wrapping from the last index to 0. At the next arbitration the search starts at that pointer.
- R3: Policy 2'b00 (and the unused code 2'b11): when no access is in progress and no request is present, the grant goes to all zero on the next edge. A request from an unconnected master produces its grant one cycle later.
- R4: Policy 2'b01: with no request, the grant stays on the last owner. That owner sees its grant in the cycle it raises a request. Any other master is granted one cycle after it asks.
- R5: Policy 2'b10: with no request, the grant moves within one cycle to the master indexed by the home-master input. The home master sees zero latency, and others pay one cycle.
- R6: A slot limit L > 0 is loaded when an access starts and counts down once per cycle while the access lasts. Once it has reached zero, the next transfer end of the owner re-arbitrates, so a master ending a beat every cycle keeps the port for L+1 beats.
- R7: The grant of a busy owner changes only on that owner's transfer-end strobe, even after the slot count has run out.
- R8: A slot limit of 0 disables the limit: an owner that keeps requesting keeps the port across any number of beats.
- R9: An owner that drops its request keeps the grant until its next transfer end, and then releases the port.
- R10: The grant is one-hot or zero. The connected flag equals the OR of the grant, and the index output names the granted bit.
- R11: During and right after reset the grant is zero, the connected flag is low and the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MASTERS | Request, one bit per master |
| xfer_end_i | input | N_MASTERS | Last cycle of a beat, one bit per master |
| policy_i | input | 2 | Idle policy: 00 drop, 01 keep last, 10 home master |
| home_master_i | input | IDX_W | Index of the home master for policy 10 |
| slot_limit_i | input | SLOT_W | Slot-cycle limit, 0 disables |
| grant_o | output | N_MASTERS | One-hot grant |
| connected_o | output | 1 | Some master owns the port |
| owner_o | output | IDX_W | Index of the granted master |

## Verification
The bench builds the block with its default parameters: four masters, an 8-bit slot field, and the limiter present. Four masters are enough to reach both the pointer wrap from index 3 to index 0 and a rotation that skips a lower-numbered requester. The 8-bit field allows small limits of 2 and 3, so expiry happens within a few beats and both the mid-beat hold and the hand-over at the beat end can be observed. A zero limit is also applied to show the unbounded burst.

// File: rtl/spa_pkg.sv
package spa_pkg;
   typedef enum logic [1:0] {
      POL_DROP = 2'b00,
      POL_LAST = 2'b01,
      POL_HOME = 2'b10
   } idle_pol_e;
endpackage

// File: rtl/spa_rr_pick.sv
// Rotating-priority search: first requester at or above ptr, else lowest.
module spa_rr_pick #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req_i,
   input  logic [IW-1:0] ptr_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);
   logic [N-1:0] upper;
   logic [N-1:0] src;

   always_comb begin
      for (int i = 0; i < N; i++) upper[i] = req_i[i] && (i >= int'(ptr_i));
      src = (|upper) ? upper : req_i;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (src[i]) idx_o = IW'(i);
      end
   end

   assign found_o = |req_i;
endmodule

// File: rtl/spa_onehot_enc.sv
// One-hot to binary, one OR-reduction per index bit.
module spa_onehot_enc #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  vec_i,
   output logic [IW-1:0] idx_o
);
   for (genvar b = 0; b < IW; b++) begin : g_bit
      logic [N-1:0] sel;
      always_comb begin
         for (int i = 0; i < N; i++) sel[i] = ((i >> b) & 1) == 1;
      end
      assign idx_o[b] = |(vec_i & sel);
   end
endmodule

// File: rtl/spa_slot_timer.sv
// Burst slot counter: loaded at access start, counts down while busy.
module spa_slot_timer #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic         run_i,
   input  logic [W-1:0] limit_i,
   output logic         expired_o
);
   logic [W-1:0] cnt_q;
   logic         armed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (load_i) begin
         cnt_q   <= limit_i;
         armed_q <= |limit_i;
      end else if (run_i && cnt_q != '0) begin
         cnt_q   <= cnt_q - 1'b1;
      end
   end

   assign expired_o = armed_q && (cnt_q == '0);
endmodule

// File: rtl/slave_port_arbiter.sv
module slave_port_arbiter
   import spa_pkg::*;
#(
   parameter int N_MASTERS     = 4,
   parameter int SLOT_W        = 8,
   parameter bit SLOT_LIMIT_EN = 1'b1,
   localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [N_MASTERS-1:0] req_i,
   input  logic [N_MASTERS-1:0] xfer_end_i,
   input  logic [1:0]           policy_i,
   input  logic [IDX_W-1:0]     home_master_i,
   input  logic [SLOT_W-1:0]    slot_limit_i,
   output logic [N_MASTERS-1:0] grant_o,
   output logic                 connected_o,
   output logic [IDX_W-1:0]     owner_o
);
   if (N_MASTERS < 2) begin : g_bad_n
      $error("slave_port_arbiter: N_MASTERS must be at least 2");
   end
   if (SLOT_W < 1) begin : g_bad_w
      $error("slave_port_arbiter: SLOT_W must be at least 1");
   end

   logic [N_MASTERS-1:0] grant_q, grant_n, home_oh, pick_oh;
   logic                 busy_q, busy_n;
   logic [IDX_W-1:0]     ptr_q, ptr_n, owner_idx, pick_idx;
   logic                 pick_found, owner_req, owner_end, slot_exp;
   logic                 arb_pt, start;
   idle_pol_e            pol;

   function automatic logic [IDX_W-1:0] after(input logic [IDX_W-1:0] i);
      return (i == IDX_W'(N_MASTERS - 1)) ? '0 : i + 1'b1;
   endfunction

   spa_onehot_enc #(.N(N_MASTERS), .IW(IDX_W)) i_enc (
      .vec_i (grant_q),
      .idx_o (owner_idx)
   );

   spa_rr_pick #(.N(N_MASTERS), .IW(IDX_W)) i_pick (
      .req_i   (req_i),
      .ptr_i   (ptr_q),
      .found_o (pick_found),
      .idx_o   (pick_idx)
   );

   if (SLOT_LIMIT_EN) begin : g_slot
      spa_slot_timer #(.W(SLOT_W)) i_slot (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .load_i    (start),
         .run_i     (busy_q),
         .limit_i   (slot_limit_i),
         .expired_o (slot_exp)
      );
   end else begin : g_noslot
      assign slot_exp = 1'b0;
   end

   assign owner_req = |(grant_q & req_i);
   assign owner_end = busy_q && |(grant_q & xfer_end_i);
   assign arb_pt    = !busy_q || (owner_end && (!owner_req || slot_exp));

   always_comb begin
      case (policy_i)
         2'b01:   pol = POL_LAST;
         2'b10:   pol = POL_HOME;
         default: pol = POL_DROP;
      endcase
      home_oh = '0;
      if (int'(home_master_i) < N_MASTERS) home_oh[home_master_i] = 1'b1;
      pick_oh = '0;
      pick_oh[pick_idx] = 1'b1;
   end

   always_comb begin
      grant_n = grant_q;
      busy_n  = busy_q;
      ptr_n   = ptr_q;
      start   = 1'b0;
      if (arb_pt) begin
         if (!busy_q && owner_req) begin
            // parked owner asks: keep it, no turnaround cycle
            busy_n = 1'b1;
            start  = 1'b1;
            ptr_n  = after(owner_idx);
         end else if (pick_found) begin
            grant_n = pick_oh;
            busy_n  = 1'b1;
            start   = 1'b1;
            ptr_n   = after(pick_idx);
         end else begin
            busy_n = 1'b0;
            case (pol)
               POL_LAST: grant_n = grant_q;
               POL_HOME: grant_n = home_oh;
               default:  grant_n = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         grant_q <= '0;
         busy_q  <= 1'b0;
         ptr_q   <= '0;
      end else begin
         grant_q <= grant_n;
         busy_q  <= busy_n;
         ptr_q   <= ptr_n;
      end
   end

   assign grant_o     = grant_q;
   assign connected_o = |grant_q;
   assign owner_o     = owner_idx;
endmodule

// File: rtl/spa_checker.sv
module spa_checker #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic [N-1:0]  req,
   input logic [N-1:0]  xfer_end,
   input logic [1:0]    policy,
   input logic [IW-1:0] home,
   input logic [N-1:0]  grant,
   input logic          connected,
   input logic [IW-1:0] owner,
   input logic          busy
);
   logic [N-1:0] home_oh;
   always_comb begin
      home_oh = '0;
      home_oh[home] = 1'b1;
   end

   assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_owner_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
      connected |-> grant[owner]);

   assert_hold_mid_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(|(grant & xfer_end))) |=> $stable(grant));

   assert_idle_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req == '0 && (policy == 2'b00 || policy == 2'b11)) |=> grant == '0);

   assert_idle_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req == '0 && policy == 2'b01) |=> $stable(grant));

   assert_idle_home_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req == '0 && policy == 2'b10) |=> grant == $past(home_oh));
endmodule

bind slave_port_arbiter spa_checker #(.N(N_MASTERS), .IW(IDX_W)) i_spa_checker (
   .clk       (clk_i),
   .rst_n     (rst_ni),
   .req       (req_i),
   .xfer_end  (xfer_end_i),
   .policy    (policy_i),
   .home      (home_master_i),
   .grant     (grant_o),
   .connected (connected_o),
   .owner     (owner_o),
   .busy      (busy_q)
);

// File: tb/test_slave_port_arbiter.sv
module test_slave_port_arbiter;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 4;
   localparam int SW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0;
   logic [N-1:0]  xe = '0;
   logic [1:0]    policy = 2'b00;
   logic [1:0]    home = '0;
   logic [SW-1:0] limit = '0;
   logic [N-1:0]  grant;
   logic          conn;
   logic [1:0]    owner;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   slave_port_arbiter #(.N_MASTERS(N), .SLOT_W(SW)) i_slave_port_arbiter (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .req_i         (req),
      .xfer_end_i    (xe),
      .policy_i      (policy),
      .home_master_i (home),
      .slot_limit_i  (limit),
      .grant_o       (grant),
      .connected_o   (conn),
      .owner_o       (owner)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_grant(string tag, logic [N-1:0] exp);
      logic [1:0] exp_own;
      exp_own = '0;
      for (int i = 0; i < N; i++) if (exp[i]) exp_own = 2'(i);
      checks++;
      if (grant !== exp || conn !== (|exp) || owner !== exp_own) begin
         errors++;
         $display("FAIL %s: grant=%b conn=%b owner=%0d, expected grant=%b conn=%b owner=%0d",
                  tag, grant, conn, owner, exp, |exp, exp_own);
      end
   endtask

   task automatic go(logic [N-1:0] r, logic [N-1:0] e);
      req = r;
      xe  = e;
      step();
   endtask

   task automatic t_reset();
      expect_grant("R11 in reset", 4'b0000);
      rst_n = 1'b1;
      step();
      expect_grant("R11 after reset", 4'b0000);
   endtask

   task automatic t_rotation();
      policy = 2'b00;
      go(4'b1011, 4'b0000); expect_grant("R1 lowest first", 4'b0001);
      go(4'b1010, 4'b0001); expect_grant("R2 next after 0", 4'b0010);
      go(4'b1001, 4'b0010); expect_grant("R2 skip to 3", 4'b1000);
      go(4'b0001, 4'b1000); expect_grant("R2 wrap to 0", 4'b0001);
      go(4'b0000, 4'b0001); expect_grant("R3 drop when idle", 4'b0000);
      xe = '0;
   endtask

   task automatic t_drop_latency();
      req = 4'b0100;
      expect_grant("R3 no grant in request cycle", 4'b0000);
      step(); expect_grant("R3 grant one cycle later", 4'b0100);
      go(4'b0000, 4'b0100); expect_grant("R3 released", 4'b0000);
      xe = '0;
   endtask

   task automatic t_keep_last();
      policy = 2'b01;
      go(4'b0010, 4'b0000); expect_grant("R4 first grant", 4'b0010);
      go(4'b0000, 4'b0010); expect_grant("R4 parked", 4'b0010);
      go(4'b0000, 4'b0000); step(); expect_grant("R4 still parked", 4'b0010);
      req = 4'b0010;
      expect_grant("R4 zero latency for last owner", 4'b0010);
      step(); expect_grant("R4 owner kept", 4'b0010);
      go(4'b0000, 4'b0010); expect_grant("R4 parked again", 4'b0010);
      req = 4'b0001; xe = '0;
      expect_grant("R4 other master waits", 4'b0010);
      step(); expect_grant("R4 other master one cycle", 4'b0001);
      go(4'b0000, 4'b0001); expect_grant("R4 parks on new owner", 4'b0001);
      xe = '0;
   endtask

   task automatic t_home();
      policy = 2'b10; home = 2'd3;
      step(); expect_grant("R5 returns to home", 4'b1000);
      req = 4'b0001;
      expect_grant("R5 non-home waits", 4'b1000);
      step(); expect_grant("R5 non-home one cycle", 4'b0001);
      go(4'b0000, 4'b0001); expect_grant("R5 back to home", 4'b1000);
      req = 4'b1000; xe = '0;
      expect_grant("R5 home zero latency", 4'b1000);
      step(); expect_grant("R5 home kept", 4'b1000);
      go(4'b0000, 4'b1000); expect_grant("R5 home parked", 4'b1000);
      xe = '0; policy = 2'b00;
      step(); expect_grant("R3 drop after policy change", 4'b0000);
   endtask

   task automatic t_slot_expiry();
      limit = 8'd3;
      go(4'b0001, 4'b0000); expect_grant("R6 burst start", 4'b0001);
      for (int k = 0; k < 3; k++) begin
         go(4'b0101, 4'b0001); expect_grant("R6 within slot", 4'b0001);
      end
      go(4'b0101, 4'b0001); expect_grant("R6 re-arbitrated after L+1 beats", 4'b0100);
      go(4'b0000, 4'b0100); expect_grant("R6 cleanup", 4'b0000);
      xe = '0;
   endtask

   task automatic t_mid_beat();
      limit = 8'd2;
      go(4'b0001, 4'b0000); expect_grant("R7 burst start", 4'b0001);
      for (int k = 0; k < 5; k++) begin
         go(4'b0101, 4'b0000); expect_grant("R7 held without beat end", 4'b0001);
      end
      go(4'b0101, 4'b0001); expect_grant("R7 switch at beat end", 4'b0100);
      go(4'b0000, 4'b0100); expect_grant("R7 cleanup", 4'b0000);
      xe = '0;
   endtask

   task automatic t_no_limit_release();
      limit = 8'd0;
      go(4'b0001, 4'b0000); expect_grant("R8 burst start", 4'b0001);
      for (int k = 0; k < 8; k++) begin
         go(4'b0101, 4'b0001); expect_grant("R8 unlimited burst", 4'b0001);
      end
      for (int k = 0; k < 2; k++) begin
         go(4'b0100, 4'b0000); expect_grant("R9 held after request drop", 4'b0001);
      end
      go(4'b0100, 4'b0001); expect_grant("R9 released at beat end", 4'b0100);
      go(4'b0000, 4'b0100); expect_grant("R9 cleanup", 4'b0000);
      xe = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_rotation();
      t_drop_latency();
      t_keep_last();
      t_home();
      t_slot_expiry();
      t_mid_beat();
      t_no_limit_release();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule